// File: doc/BRIEF.md
# Split X/Y Dual-Read Data Memory

This block is a word-addressed data store cut at a fixed address into a lower X region and an upper Y region. Ordinary single-operand accesses use one unified port that reaches every word: a write stores data and each unified access also returns the addressed word. Dual-operand multiply-accumulate fetches use a second request that reads one word from X and one word from Y in the same cycle. The unified read and the X operand share one X read bus. The Y bus is only ever loaded by a dual fetch. Every write, whatever its source, is decoded against the whole combined range.

Each access path has its own small address generator. It offers linear addressing and modulo addressing against a shared start/end window. A bit-reversed mode is honoured only for unified writes that land in X. The split point is an elaboration parameter. A dual fetch whose X address leaves X, or whose Y address leaves Y, raises an error flag and returns zero on the offending bus.

Top module: `xy_dual_mem`

## Requirements
- R1: After reset, x_rdata, y_rdata and d_err are all zero.
- R2: A unified access (u_en=1) to any address in the full range returns that word on x_rdata one cycle later. When u_we=1 it also stores u_wdata at the effective address.
- R3: When a unified access writes and reads the same address in one cycle, x_rdata shows the previous contents, and a later read shows the new value.
- R4: A dual fetch (d_en=1) places the X word on x_rdata and the Y word on y_rdata together, one cycle later.
- R5: In a dual fetch, an X effective address at or above SPLIT zeroes x_rdata, and a Y effective address below SPLIT zeroes y_rdata. In either case d_err is 1 in that same result cycle. d_err is 0 after an error-free dual fetch.
- R6: When d_en and u_en are both high, the X bus carries the dual X word. The unified read is dropped, but a unified write still takes effect.
- R7: Mode code 1 (modulo) maps an address above mod_end to mod_start + (addr − mod_end − 1), modulo 2^AW. Other addresses pass unchanged. This applies to the unified port and to both dual ports.
- R8: Mode code 2 (bit-reverse) reverses the low brev_n bits of the address only on a unified write whose raw address is below SPLIT. On unified reads, on writes at or above SPLIT and on the dual ports, codes 2 and 3 act as linear (code 0).
- R9: y_rdata holds its value in any cycle with no dual fetch. x_rdata holds its value in any cycle with no read of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mod_start | input | AW | Modulo window start address |
| mod_end | input | AW | Modulo window end address |
| brev_n | input | NBW | Number of low address bits reversed in bit-reverse mode |
| u_en | input | 1 | Unified access request |
| u_we | input | 1 | Unified access is a write |
| u_mode | input | 2 | Unified address mode: 0 linear, 1 modulo, 2 bit-reverse |
| u_addr | input | AW | Unified raw address |
| u_wdata | input | DW | Unified write data |
| d_en | input | 1 | Dual-operand fetch request |
| dx_mode | input | 2 | X fetch address mode |
| dx_addr | input | AW | X fetch raw address |
| dy_mode | input | 2 | Y fetch address mode |
| dy_addr | input | AW | Y fetch raw address |
| x_rdata | output | DW | X read bus: unified read data or dual X operand |
| y_rdata | output | DW | Y read bus: dual Y operand |
| d_err | output | 1 | Dual fetch address error |

## Verification
Every result of this block is due exactly one clock edge after the request: x_rdata, y_rdata and d_err are all registered at the edge that samples the request. The bench drives each request just after a rising edge and waits for the next rising edge. It then samples 1 ns later, before the next request changes anything. Hold behaviour and write effects are checked by a later separate read, so the written state is observed through the ports rather than inside the design.

// File: rtl/xy_mem_pkg.sv
package xy_mem_pkg;
  typedef enum logic [1:0] {
    AM_LIN  = 2'd0,
    AM_MOD  = 2'd1,
    AM_BREV = 2'd2,
    AM_RSVD = 2'd3
  } amode_e;
endpackage

// File: rtl/xy_agu.sv
module xy_agu
  import xy_mem_pkg::*;
#(
  parameter int AW  = 8,
  parameter int NBW = 4
) (
  input  logic [AW-1:0]  raw,
  input  amode_e         mode,
  input  logic           brev_ok,
  input  logic [AW-1:0]  m_start,
  input  logic [AW-1:0]  m_end,
  input  logic [NBW-1:0] nbits,
  output logic [AW-1:0]  ea
);
  // Wrap past the window end back to its start, keeping the overshoot.
  function automatic logic [AW-1:0] mod_wrap(input logic [AW-1:0] a,
                                             input logic [AW-1:0] s,
                                             input logic [AW-1:0] e);
    if (a > e) return s + (a - e - AW'(1));
    return a;
  endfunction

  // Mirror the low n bits of the address; upper bits untouched.
  function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] a,
                                            input logic [NBW-1:0] n);
    logic [AW-1:0] r;
    int nn;
    nn = (int'(n) > AW) ? AW : int'(n);
    r  = a;
    for (int i = 0; i < AW; i++)
      if (i < nn) r[i] = a[nn-1-i];
    return r;
  endfunction

  always_comb begin
    unique case (mode)
      AM_MOD:  ea = mod_wrap(raw, m_start, m_end);
      AM_BREV: ea = brev_ok ? bit_rev(raw, nbits) : raw;
      default: ea = raw;
    endcase
  end

  always_comb begin
    if (mode == AM_MOD && raw <= m_end)
      a_r7_mod_inside: assert (ea == raw) else $error("R7 modulo moved an in-window address");
    if (mode == AM_BREV && !brev_ok)
      a_r8_brev_gated: assert (ea == raw) else $error("R8 bit-reverse applied where not allowed");
  end
endmodule

// File: rtl/xy_bank.sv
module xy_bank #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rx_en,
  input  logic [AW-1:0] rx_addr,
  input  logic          ry_en,
  input  logic [AW-1:0] ry_addr,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
  end

  // Reads sample the array before this edge's write lands: old data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (rx_en) x_q <= mem[rx_addr];
      if (ry_en) y_q <= mem[ry_addr];
    end
  end
endmodule

// File: rtl/xy_dual_mem.sv
module xy_dual_mem
  import xy_mem_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int SPLIT = 128,
  parameter int NBW   = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  mod_start,
  input  logic [AW-1:0]  mod_end,
  input  logic [NBW-1:0] brev_n,
  input  logic           u_en,
  input  logic           u_we,
  input  logic [1:0]     u_mode,
  input  logic [AW-1:0]  u_addr,
  input  logic [DW-1:0]  u_wdata,
  input  logic           d_en,
  input  logic [1:0]     dx_mode,
  input  logic [AW-1:0]  dx_addr,
  input  logic [1:0]     dy_mode,
  input  logic [AW-1:0]  dy_addr,
  output logic [DW-1:0]  x_rdata,
  output logic [DW-1:0]  y_rdata,
  output logic           d_err
);
  localparam logic [AW-1:0] SPLIT_A = AW'(SPLIT);

  logic [AW-1:0] u_ea;
  logic          u_brev_ok;
  logic [AW-1:0] d_raw [2];
  amode_e        d_mode [2];
  logic [AW-1:0] d_ea [2];
  logic          x_bad, y_bad;
  logic          xz_q, yz_q;
  logic [DW-1:0] bx_q, by_q;

  assign u_brev_ok = u_we && (u_addr < SPLIT_A);

  xy_agu #(.AW(AW), .NBW(NBW)) u_agu_u (
    .raw(u_addr), .mode(amode_e'(u_mode)), .brev_ok(u_brev_ok),
    .m_start(mod_start), .m_end(mod_end), .nbits(brev_n), .ea(u_ea)
  );

  assign d_raw[0]  = dx_addr;
  assign d_raw[1]  = dy_addr;
  assign d_mode[0] = amode_e'(dx_mode);
  assign d_mode[1] = amode_e'(dy_mode);

  // Port 0 feeds X, port 1 feeds Y; bit-reverse never applies to reads.
  for (genvar p = 0; p < 2; p++) begin : g_dagu
    xy_agu #(.AW(AW), .NBW(NBW)) u_agu_d (
      .raw(d_raw[p]), .mode(d_mode[p]), .brev_ok(1'b0),
      .m_start(mod_start), .m_end(mod_end), .nbits(brev_n), .ea(d_ea[p])
    );
  end

  assign x_bad = d_ea[0] >= SPLIT_A;
  assign y_bad = d_ea[1] <  SPLIT_A;

  xy_bank #(.DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wen(u_en && u_we), .waddr(u_ea), .wdata(u_wdata),
    .rx_en(d_en || u_en), .rx_addr(d_en ? d_ea[0] : u_ea),
    .ry_en(d_en), .ry_addr(d_ea[1]),
    .x_q(bx_q), .y_q(by_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xz_q  <= 1'b0;
      yz_q  <= 1'b0;
      d_err <= 1'b0;
    end else begin
      d_err <= d_en && (x_bad || y_bad);
      if (d_en) begin
        xz_q <= x_bad;
        yz_q <= y_bad;
      end else if (u_en) begin
        xz_q <= 1'b0;
      end
    end
  end

  assign x_rdata = xz_q ? '0 : bx_q;
  assign y_rdata = yz_q ? '0 : by_q;

  a_r5_x_outside: assert property (@(posedge clk) disable iff (!rst_n)
    d_en && x_bad |=> (x_rdata == '0) && d_err) else $error("R5 X error not reported");
  a_r5_y_outside: assert property (@(posedge clk) disable iff (!rst_n)
    d_en && y_bad |=> (y_rdata == '0) && d_err) else $error("R5 Y error not reported");
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    d_err |-> (x_rdata == '0) || (y_rdata == '0)) else $error("R5 error without zeroed bus");
  a_r9_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !d_en |=> $stable(y_rdata)) else $error("R9 Y bus changed without dual fetch");
  a_r8_brev_y_linear: assert property (@(posedge clk) disable iff (!rst_n)
    u_en && u_we && u_mode == 2'd2 && u_addr >= SPLIT_A |-> u_ea == u_addr)
    else $error("R8 bit-reverse on Y write");
endmodule

// File: tb/sim_xy_dual_mem.sv
module sim_xy_dual_mem;
  localparam int DW = 16, AW = 8, SPLIT = 128, NBW = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] mod_start = 0, mod_end = 0;
  logic [NBW-1:0] brev_n = 0;
  logic u_en = 0, u_we = 0, d_en = 0;
  logic [1:0] u_mode = 0, dx_mode = 0, dy_mode = 0;
  logic [AW-1:0] u_addr = 0, dx_addr = 0, dy_addr = 0;
  logic [DW-1:0] u_wdata = 0;
  logic [DW-1:0] x_rdata, y_rdata;
  logic d_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] mm [256];

  always #2 clk = ~clk;

  xy_dual_mem #(.DW(DW), .AW(AW), .SPLIT(SPLIT), .NBW(NBW)) u0 (.*);

  function automatic logic [AW-1:0] ref_ea(input logic [AW-1:0] a, input int md, input bit brev_allowed);
    logic [AW-1:0] r;
    r = a;
    if (md == 1 && a > mod_end) r = AW'(int'(mod_start) + int'(a) - int'(mod_end) - 1);
    if (md == 2 && brev_allowed)
      for (int i = 0; i < int'(brev_n); i++) r[i] = a[int'(brev_n) - 1 - i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ucyc(input bit we, input logic [1:0] md, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    u_en = 1; u_we = we; u_mode = md; u_addr = a; u_wdata = wd;
    @(posedge clk); #1;
    u_en = 0; u_we = 0;
  endtask

  task automatic dcyc(input logic [1:0] xm, input logic [AW-1:0] xa, input logic [1:0] ym, input logic [AW-1:0] ya);
    d_en = 1; dx_mode = xm; dx_addr = xa; dy_mode = ym; dy_addr = ya;
    @(posedge clk); #1;
    d_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 x_rdata", x_rdata, 0);
    chk("R1 y_rdata", y_rdata, 0);
    chk("R1 d_err", {15'd0, d_err}, 0);
  endtask

  task automatic t_fill_read;
    for (int a = 0; a < 256; a++) begin
      mm[a] = {8'(a), 8'(~a)};
      ucyc(1, 0, 8'(a), mm[a]);
    end
    ucyc(0, 0, 8'd7, 0);   chk("R2 read X", x_rdata, mm[7]);
    ucyc(0, 0, 8'd200, 0); chk("R2 read Y", x_rdata, mm[200]);
  endtask

  task automatic t_rw_same;
    ucyc(1, 0, 8'd10, 16'h1234); chk("R3 old data", x_rdata, mm[10]);
    mm[10] = 16'h1234;
    ucyc(0, 0, 8'd10, 0); chk("R3 new data", x_rdata, 16'h1234);
  endtask

  task automatic t_dual;
    dcyc(0, 8'd3, 0, 8'd250);
    chk("R4 X word", x_rdata, mm[3]); chk("R4 Y word", y_rdata, mm[250]);
    chk("R5 no err", {15'd0, d_err}, 0);
    dcyc(0, 8'd127, 0, 8'd128);
    chk("R4 X edge", x_rdata, mm[127]); chk("R4 Y edge", y_rdata, mm[128]);
    @(posedge clk); #1;
    chk("R9 Y hold", y_rdata, mm[128]); chk("R9 X hold", x_rdata, mm[127]);
  endtask

  task automatic t_err;
    dcyc(0, 8'd200, 0, 8'd140);
    chk("R5 X zero", x_rdata, 0); chk("R5 Y ok", y_rdata, mm[140]);
    chk("R5 err set", {15'd0, d_err}, 1);
    dcyc(0, 8'd20, 0, 8'd10);
    chk("R5 X ok", x_rdata, mm[20]); chk("R5 Y zero", y_rdata, 0);
    chk("R5 err set Y", {15'd0, d_err}, 1);
    dcyc(0, 8'd21, 0, 8'd131);
    chk("R5 err clear", {15'd0, d_err}, 0);
  endtask

  task automatic t_prio;
    u_en = 1; u_we = 1; u_mode = 0; u_addr = 8'd6; u_wdata = 16'hBEEF;
    dcyc(0, 8'd5, 0, 8'd129);
    u_en = 0; u_we = 0;
    chk("R6 X bus dual", x_rdata, mm[5]);
    mm[6] = 16'hBEEF;
    ucyc(0, 0, 8'd6, 0); chk("R6 write kept", x_rdata, 16'hBEEF);
  endtask

  task automatic t_modulo;
    mod_start = 8'd16; mod_end = 8'd31;
    ucyc(0, 1, 8'd33, 0); chk("R7 unified wrap", x_rdata, mm[ref_ea(8'd33, 1, 0)]);
    chk("R7 unified wrap abs", x_rdata, mm[17]);
    ucyc(0, 1, 8'd20, 0); chk("R7 inside", x_rdata, mm[20]);
    dcyc(1, 8'd32, 1, 8'd150);
    chk("R7 X wrap", x_rdata, mm[16]); chk("R7 Y wrap", y_rdata, mm[134]);
  endtask

  task automatic t_brev;
    logic [AW-1:0] e;
    brev_n = 4'd4;
    e = ref_ea(8'h03, 2, 1);
    ucyc(1, 2, 8'h03, 16'hC0DE); mm[e] = 16'hC0DE;
    ucyc(0, 0, 8'h0C, 0); chk("R8 X write reversed", x_rdata, 16'hC0DE);
    ucyc(0, 2, 8'h03, 0); chk("R8 read linear", x_rdata, mm[8'h03]);
    ucyc(1, 2, 8'h83, 16'hFACE); mm[8'h83] = 16'hFACE;
    ucyc(0, 0, 8'h83, 0); chk("R8 Y write linear", x_rdata, 16'hFACE);
    ucyc(0, 0, 8'h8C, 0); chk("R8 Y untouched", x_rdata, mm[8'h8C]);
    dcyc(2, 8'h03, 2, 8'h83);
    chk("R8 dual X linear", x_rdata, mm[8'h03]); chk("R8 dual Y linear", y_rdata, 16'hFACE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_fill_read();
    t_rw_same();
    t_dual();
    t_err();
    t_prio();
    t_modulo();
    t_brev();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule